// File: doc/BRIEF.md
# Programmable Feedback Divider with Transmit Offset

This block is the feedback divider of a frequency synthesizer. It is clocked by the signal taken from the oscillator, and it emits one pulse on `fv_pulse` for every E cycles of that clock. The pulse train goes to the phase comparator. E, the effective modulus, is the 14-bit programming word `n_prog`, optionally raised by a fixed offset of 856. That offset lets a transceiver move its loop frequency by the intermediate frequency when it switches from receive to transmit.

A down counter reloads from the offset sum whenever it reaches zero. The programming word and the select are therefore only taken in at that reload moment, so a period already in progress always runs to its full length. The sum is truncated to the counter width. A reload whose sum overflowed is reported on `sum_wrap` so that a test can observe it. An effective modulus of 0 or 1 gives divide-by-1.

Top module: `fb_divider`

## Requirements
- R1: While `rst` is high at a clock edge, `fv_pulse` and `sum_wrap` are low after that edge. The first `fv_pulse` appears on the first edge at which `rst` is low.
- R2: When `tx_rx` is 0, the effective modulus is `n_prog` + 856, taken modulo 16384.
- R3: When `tx_rx` is 1, the effective modulus is `n_prog` itself, with no offset added.
- R4: For an effective modulus E of 2 or more, `fv_pulse` is high for exactly one cycle. Consecutive rising pulses are exactly E clock cycles apart.
- R5: An effective modulus of 0 or 1 makes `fv_pulse` high on every clock cycle, which is divide-by-1.
- R6: `sum_wrap` is 1 when `n_prog` plus the selected offset is 16384 or more, and 0 otherwise. It changes only on edges where `fv_pulse` goes or stays high, which are the reload edges.
- R7: `n_prog` and `tx_rx` are sampled only at a reload. A change made during a period leaves that period at the length it started with, and the new value governs the period that follows the next pulse.
- R8: The undriven input state, with every `n_prog` bit at 1 and `tx_rx` at 1, gives the largest modulus, 16383.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input frequency from the oscillator, used as the clock |
| rst | input | 1 | Synchronous active-high reset |
| n_prog | input | 14 | Programming word; bit 0 is least significant |
| tx_rx | input | 1 | 0 adds the 856 offset, 1 adds nothing |
| fv_pulse | output | 1 | Registered divided output pulse |
| sum_wrap | output | 1 | Registered overflow flag of the reload sum |

## Verification
Any corruption of the counter's count shows up at the ports within one period. It appears as a pulse interval that does not match E for the programmed word. A wrong reload value, whether from a missing or misapplied offset or a broken divide-by-1 clamp, gives a wrong interval on the first full period after the word is taken in. An input that is taken in at the wrong moment shortens or stretches the period in progress, and this shows at the very next pulse. A bad carry shows on `sum_wrap` at the reload pulse itself.

// File: rtl/fb_divider_pkg.sv
package fb_divider_pkg;
  localparam int unsigned FBD_WIDTH  = 14;
  localparam int unsigned FBD_OFFSET = 856;
endpackage

// File: rtl/fbd_offset_adder.sv
module fbd_offset_adder #(
  parameter int unsigned W      = 14,
  parameter int unsigned OFFSET = 856
) (
  input  logic [W-1:0] n_word,
  input  logic         add_off_n,
  output logic [W-1:0] reload,
  output logic         carry
);
  localparam logic [W:0] OFF_EXT = (W+1)'(OFFSET);
  localparam logic [W:0] ONE_EXT = (W+1)'(1);

  logic [W:0] sum_ext;
  logic [W-1:0] sum_trunc;

  always_comb begin
    sum_ext   = {1'b0, n_word} + (add_off_n ? '0 : OFF_EXT);
    sum_trunc = sum_ext[W-1:0];
    carry     = sum_ext[W];
    // Counter reloads with E-1; E of 0 or 1 clamps to divide-by-1
    if ({1'b0, sum_trunc} <= ONE_EXT) reload = '0;
    else                              reload = sum_trunc - 1'b1;
  end
endmodule

// File: rtl/fbd_down_counter.sv
module fbd_down_counter #(
  parameter int unsigned W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] reload,
  output logic         at_zero
);
  logic [W-1:0] cnt_q;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (at_zero) cnt_q <= reload;
    else              cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/fbd_pulse_reg.sv
module fbd_pulse_reg (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic carry_in,
  output logic pulse_q,
  output logic wrap_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      wrap_q  <= 1'b0;
    end else begin
      pulse_q <= fire;
      if (fire) wrap_q <= carry_in;
    end
  end
endmodule

// File: rtl/fb_divider.sv
module fb_divider
  import fb_divider_pkg::*;
#(
  parameter int unsigned W      = FBD_WIDTH,
  parameter int unsigned OFFSET = FBD_OFFSET
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] n_prog,
  input  logic         tx_rx,
  output logic         fv_pulse,
  output logic         sum_wrap
);
  logic [W-1:0] reload_val;
  logic         sum_carry;
  logic         cnt_zero;

  fbd_offset_adder #(.W(W), .OFFSET(OFFSET)) u_add (
    .n_word    (n_prog),
    .add_off_n (tx_rx),
    .reload    (reload_val),
    .carry     (sum_carry)
  );

  fbd_down_counter #(.W(W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .reload  (reload_val),
    .at_zero (cnt_zero)
  );

  fbd_pulse_reg u_out (
    .clk      (clk),
    .rst      (rst),
    .fire     (cnt_zero),
    .carry_in (sum_carry),
    .pulse_q  (fv_pulse),
    .wrap_q   (sum_wrap)
  );
endmodule

// File: rtl/fb_divider_chk.sv
module fb_divider_chk #(
  parameter int unsigned W      = 14,
  parameter int unsigned OFFSET = 856
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] n_prog,
  input logic         tx_rx,
  input logic         fv_pulse,
  input logic         sum_wrap,
  input logic         at_zero
);
  logic [W:0] chk_sum;
  logic       small_mod;

  always_comb begin
    chk_sum   = {1'b0, n_prog} + (tx_rx ? '0 : (W+1)'(OFFSET));
    small_mod = (chk_sum[W-1:0] <= W'(1));
  end

  // R1: reset clears both outputs
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!fv_pulse && !sum_wrap));

  // R4: a counter terminal state is followed by an output pulse
  a_r4_pulse_on_zero: assert property (@(posedge clk) disable iff (rst)
    at_zero |=> fv_pulse);

  // R4: no pulse without a terminal state
  a_r4_quiet_off_zero: assert property (@(posedge clk) disable iff (rst)
    !at_zero |=> !fv_pulse);

  // R5: modulus 0 or 1 reloads straight back to terminal
  a_r5_div1_repeat: assert property (@(posedge clk) disable iff (rst)
    (at_zero && small_mod) |=> at_zero);

  // R6: overflow flag only moves at reload pulses
  a_r6_wrap_held: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !fv_pulse) |-> $stable(sum_wrap));
endmodule

bind fb_divider fb_divider_chk #(.W(W), .OFFSET(OFFSET)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .n_prog   (n_prog),
  .tx_rx    (tx_rx),
  .fv_pulse (fv_pulse),
  .sum_wrap (sum_wrap),
  .at_zero  (cnt_zero)
);

// File: tb/tb_fb_divider.sv
module tb_fb_divider;
  localparam int W = 14;
  localparam int OFF = 856;
  localparam int LIMIT = 195000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] n_prog = '1;
  logic tx_rx = 1'b1;
  logic fv_pulse, sum_wrap;

  always #2.5 clk = ~clk;

  fb_divider dut (
    .clk(clk), .rst(rst), .n_prog(n_prog), .tx_rx(tx_rx),
    .fv_pulse(fv_pulse), .sum_wrap(sum_wrap)
  );

  typedef struct {
    int    first;
    int    left;
    int    period;
    bit    chk_wrap;
    bit    wrap;
    string req;
  } exp_t;

  exp_t q[$];
  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;
  int pidx    = 0;
  int last_t  = -1;
  bit done    = 0;

  function automatic int exp_mod(int n, bit tr);
    int s = n + (tr ? 0 : OFF);
    s = s % (1 << W);
    return (s <= 1) ? 1 : s;
  endfunction

  function automatic bit exp_wrap(int n, bit tr);
    return (n + (tr ? 0 : OFF)) >= (1 << W);
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  // monitor: interval and flag scoreboard
  always @(negedge clk) begin
    cyc++;
    if (!rst && fv_pulse) begin
      pidx++;
      if (last_t >= 0 && q.size() > 0 && pidx >= q[0].first) begin
        vectors++;
        if (cyc - last_t != q[0].period) begin
          errors++;
          $display("FAIL %s: interval %0d expected %0d", q[0].req, cyc - last_t, q[0].period);
        end
        if (q[0].chk_wrap) begin
          vectors++;
          if (sum_wrap !== q[0].wrap) begin
            errors++;
            $display("FAIL R6: sum_wrap %0b expected %0b", sum_wrap, q[0].wrap);
          end
        end
        q[0].left--;
        if (q[0].left == 0) void'(q.pop_front());
      end
      last_t = cyc;
    end
    if (cyc > LIMIT && !done) begin
      errors++;
      $display("FAIL watchdog: cycle %0d expected below %0d", cyc, LIMIT);
      finish_run();
    end
  end

  task automatic wait_pulse();
    do begin
      @(posedge clk);
      #1;
    end while (!fv_pulse);
  endtask

  int prev_n = (1 << W) - 1;
  bit prev_tr = 1'b1;

  // driver: reprogram just after a pulse; R7 says the old value finishes the next interval
  task automatic run_cfg(int n, bit tr, int count, string req);
    exp_t old_e, new_e;
    wait_pulse();
    n_prog = W'(n);
    tx_rx  = tr;
    old_e.first = pidx + 2; old_e.left = 1; old_e.period = exp_mod(prev_n, prev_tr);
    old_e.chk_wrap = 0; old_e.wrap = 0; old_e.req = "R7";
    new_e.first = pidx + 3; new_e.left = count; new_e.period = exp_mod(n, tr);
    new_e.chk_wrap = 1; new_e.wrap = exp_wrap(n, tr); new_e.req = req;
    q.push_back(old_e);
    q.push_back(new_e);
    prev_n = n; prev_tr = tr;
    repeat (count + 2) wait_pulse();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    vectors++;
    if (fv_pulse !== 1'b0 || sum_wrap !== 1'b0) begin
      errors++;
      $display("FAIL R1: fv=%b wrap=%b expected 0 0", fv_pulse, sum_wrap);
    end
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    vectors++;
    if (fv_pulse !== 1'b1) begin
      errors++;
      $display("FAIL R1: first pulse %b expected 1", fv_pulse);
    end
    run_cfg(100,   1'b1, 3, "R3");
    run_cfg(100,   1'b0, 3, "R2");
    run_cfg(2,     1'b1, 4, "R4");
    run_cfg(5,     1'b1, 4, "R4");
    run_cfg(1,     1'b1, 4, "R5");
    run_cfg(0,     1'b1, 4, "R5");
    run_cfg(0,     1'b0, 2, "R2");
    run_cfg(15528, 1'b0, 3, "R6");
    run_cfg(16383, 1'b0, 2, "R6");
    run_cfg(16383, 1'b1, 2, "R8");
    run_cfg(7,     1'b0, 2, "R2");
    wait_pulse();
    wait_pulse();
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R4: %0d scoreboard items left expected 0", q.size());
    end
    done = 1;
    finish_run();
  end
endmodule